// File: doc/BRIEF.md
# Segment Selector Load Unit

This block takes a 16-bit selector and a segment-register id, and fills that register's hidden copy of the descriptor: base, expanded limit and attribute bits. The selector is split into a 13-bit index, a table-select bit and a requested-privilege field. The index is bounds-checked against the limit of the chosen table, and the 8-byte descriptor is then read as two 32-bit words over a valid/ready memory port. If the descriptor's accessed flag is clear, the unit writes that flag back to memory with a single byte strobe before it commits the new contents.

The unit also holds the base, limit and selector registers for the global and local descriptor tables. A combinational access check adds an offset to a cached base and tests the last byte of the access against the cached limit. A selector with index 0 that selects the global table loads without any memory traffic and without a fault into any register except the code and stack registers. The register is then marked unusable, so every later access check through it reports a fault.

Top module: `seg_selector_loader`

## Requirements
- R1: The selector is split as index = sel[15:3], table select = sel[2] (0 picks the global table, 1 the local table) and RPL = sel[1:0]. The register then reports the full 16-bit selector that was loaded.
- R2: The descriptor is read at table base + index × 8, first word at that address and second word at that address + 4.
- R3: A selector with sel[15:2] = 0 makes no memory request. Into register id 1 (code) or id 2 (stack) it completes with fault code 3. Into any other register it completes with fault code 0 and marks the register unusable.
- R4: When index × 8 + 7 exceeds the selected table's 16-bit limit, the load completes with fault code 1, makes no memory request and leaves the register unchanged.
- R5: When the second word's bit 15 (present) is 0, the load completes with fault code 2 and leaves the register's base, limit and usable flag unchanged.
- R6: The base is assembled from word1[31:24], word1[7:0] and word0[31:16]. The raw 20-bit limit is word1[19:16] followed by word0[15:0]. The attributes are reported as rd_attr = {word1[23:20], word1[15:8]}.
- R7: With word1[23] = 0 the expanded limit is the raw limit. With word1[23] = 1 it is the raw limit shifted left by 12 with the low 12 bits set to ones.
- R8: If word1[8] (accessed) is clear, exactly one write goes to base + index × 8 + 4 with strobe 4'b0010 and bit 8 set. If it is already set, no write is made. In both cases the cached rd_attr[0] is 1.
- R9: After reset both tables have base 0 and limit 0xFFFF, the local-table selector is 0, and every register reads selector 0 and unusable.
- R10: chk_linear = cached base + chk_off. chk_fault is 1 when the register is unusable or when chk_off + chk_size − 1, computed without wrap, exceeds the expanded limit.
- R11: ld_busy rises the cycle after an accepted ld_req and stays high through a one-cycle ld_done, which carries the fault code. A request made while busy is ignored. Address and write flag stay stable while mem_valid is high and mem_ready is low.
- R12: A table write with tbl_local = 0 sets the global base and limit. With tbl_local = 1 it sets the local base, limit and selector, and ldt_sel shows that selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_req | input | 1 | Start a selector load |
| ld_sel | input | 16 | Selector to load |
| ld_seg | input | 3 | Target register id |
| ld_busy | output | 1 | Load in progress |
| ld_done | output | 1 | One-cycle completion pulse |
| ld_fault | output | 2 | Fault code, valid with ld_done |
| tbl_we | input | 1 | Table register write |
| tbl_local | input | 1 | 0 global table, 1 local table |
| tbl_base | input | 32 | Table base to write |
| tbl_limit | input | 16 | Table limit to write |
| tbl_sel | input | 16 | Local-table selector to write |
| ldt_sel | output | 16 | Current local-table selector |
| rd_seg | input | 3 | Register id to read back |
| rd_sel | output | 16 | Cached selector |
| rd_usable | output | 1 | Register holds a usable descriptor |
| rd_base | output | 32 | Cached base |
| rd_limit | output | 32 | Cached expanded limit |
| rd_attr | output | 12 | Cached attribute bits |
| chk_seg | input | 3 | Register id for access check |
| chk_off | input | 32 | Access offset |
| chk_size | input | 3 | Access size in bytes, 1 to 4 |
| chk_linear | output | 32 | Base plus offset |
| chk_fault | output | 1 | Access outside limit or unusable |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_write | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte strobes for a write |
| mem_rdata | input | 32 | Read data, valid in the accepting cycle |

## Verification
If the controller latches a word wrongly or the state goes wrong, rd_base, rd_limit or rd_attr show it in the first cycle after ld_done. An unintended commit on a fault shows there as a base or usable flag that differs from its value before the load. A bad descriptor address or a bad table-limit decision shows at the memory port itself, in the first request's address or in a request that should not have been made. Errors in the fill of the expanded limit stay hidden until an access check lands on the exact last byte, so the checks probe both sides of that boundary, including an offset that wraps past 2^32.

// File: rtl/seg_ld_pkg.sv
package seg_ld_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_TABLE  = 2'd1,
    FLT_ABSENT = 2'd2,
    FLT_NULLCS = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LO,
    ST_RD_HI,
    ST_WB,
    ST_DONE
  } ld_state_e;
endpackage

// File: rtl/seg_ld_tables.sv
module seg_ld_tables #(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 16,
  parameter int IDX_W  = 13
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                wr_en,
  input  logic                wr_local,
  input  logic [ADDR_W-1:0]   wr_base,
  input  logic [LIM_W-1:0]    wr_limit,
  input  logic [IDX_W+2:0]    wr_sel,
  input  logic [IDX_W:0]      sel_hi,
  output logic [ADDR_W-1:0]   desc_addr,
  output logic                lim_fault,
  output logic [IDX_W+2:0]    ldt_sel
);
  logic [ADDR_W-1:0] gbase_q, lbase_q;
  logic [LIM_W-1:0]  glim_q, llim_q;
  logic [IDX_W+2:0]  lsel_q;
  logic              g_en, l_en;
  logic [IDX_W-1:0]  idx;
  logic              use_local;
  logic [IDX_W+2:0]  last_byte;

  assign g_en = wr_en && !wr_local;
  assign l_en = wr_en && wr_local;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      gbase_q <= '0;
      glim_q  <= '1;
    end else if (g_en) begin
      gbase_q <= wr_base;
      glim_q  <= wr_limit;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lbase_q <= '0;
      llim_q  <= '1;
      lsel_q  <= '0;
    end else if (l_en) begin
      lbase_q <= wr_base;
      llim_q  <= wr_limit;
      lsel_q  <= wr_sel;
    end
  end

  assign idx       = sel_hi[IDX_W:1];
  assign use_local = sel_hi[0];
  assign last_byte = {idx, 3'b111};

  always_comb begin
    if (use_local) begin
      desc_addr = lbase_q + ADDR_W'({idx, 3'b000});
      lim_fault = LIM_W'(last_byte) > llim_q;
    end else begin
      desc_addr = gbase_q + ADDR_W'({idx, 3'b000});
      lim_fault = LIM_W'(last_byte) > glim_q;
    end
  end

  assign ldt_sel = lsel_q;
endmodule

// File: rtl/seg_ld_unpack.sv
module seg_ld_unpack (
  input  logic [31:0] lo_word,
  input  logic [31:0] hi_word,
  output logic [31:0] base,
  output logic [31:0] limit,
  output logic [11:0] attr
);
  logic [19:0] raw_lim;
  logic        gran;

  assign raw_lim = {hi_word[19:16], lo_word[15:0]};
  assign gran    = hi_word[23];
  assign base    = {hi_word[31:24], hi_word[7:0], lo_word[31:16]};
  assign limit   = gran ? {raw_lim, 12'hFFF} : {12'h000, raw_lim};
  assign attr    = {hi_word[23:20], hi_word[15:8]};
endmodule

// File: rtl/seg_ld_cache.sv
module seg_ld_cache #(
  parameter int NUM_SEG = 6,
  parameter int SEG_W   = 3,
  parameter int SEL_W   = 16,
  parameter int ATTR_W  = 12
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               we,
  input  logic [SEG_W-1:0]   w_seg,
  input  logic [SEL_W-1:0]   w_sel,
  input  logic               w_usable,
  input  logic [31:0]        w_base,
  input  logic [31:0]        w_limit,
  input  logic [ATTR_W-1:0]  w_attr,
  input  logic [SEG_W-1:0]   r_seg,
  output logic [SEL_W-1:0]   r_sel,
  output logic               r_usable,
  output logic [31:0]        r_base,
  output logic [31:0]        r_limit,
  output logic [ATTR_W-1:0]  r_attr,
  input  logic [SEG_W-1:0]   c_seg,
  input  logic [31:0]        c_off,
  input  logic [2:0]         c_size,
  output logic [31:0]        c_linear,
  output logic               c_fault
);
  logic [SEL_W-1:0]  sel_q  [NUM_SEG];
  logic              use_q  [NUM_SEG];
  logic [31:0]       base_q [NUM_SEG];
  logic [31:0]       lim_q  [NUM_SEG];
  logic [ATTR_W-1:0] attr_q [NUM_SEG];
  logic [NUM_SEG-1:0] hit;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_hit
    assign hit[g] = we && (w_seg == SEG_W'(g));
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SEG; i++) begin
        sel_q[i]  <= '0;
        use_q[i]  <= 1'b0;
        base_q[i] <= '0;
        lim_q[i]  <= '0;
        attr_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_SEG; i++) begin
        if (hit[i]) begin
          sel_q[i]  <= w_sel;
          use_q[i]  <= w_usable;
          base_q[i] <= w_base;
          lim_q[i]  <= w_limit;
          attr_q[i] <= w_attr;
        end
      end
    end
  end

  logic [32:0] last_off;
  logic        c_in_range;

  always_comb begin
    r_sel = '0; r_usable = 1'b0; r_base = '0; r_limit = '0; r_attr = '0;
    if (32'(r_seg) < NUM_SEG) begin
      r_sel    = sel_q[r_seg];
      r_usable = use_q[r_seg];
      r_base   = base_q[r_seg];
      r_limit  = lim_q[r_seg];
      r_attr   = attr_q[r_seg];
    end
  end

  assign c_in_range = 32'(c_seg) < NUM_SEG;
  assign last_off   = {1'b0, c_off} + 33'(c_size) - 33'd1;

  always_comb begin
    c_linear = c_off;
    c_fault  = 1'b1;
    if (c_in_range) begin
      c_linear = base_q[c_seg] + c_off;
      c_fault  = !use_q[c_seg] || (last_off > {1'b0, lim_q[c_seg]});
    end
  end

  // R10: an entry just written unusable must fail any access check on it
  assert_unusable_faults_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (we && !w_usable && c_in_range && (c_seg == w_seg)) ##1 (c_seg == $past(w_seg)) |-> c_fault);
endmodule

// File: rtl/seg_selector_loader.sv
module seg_selector_loader
  import seg_ld_pkg::*;
#(
  parameter int NUM_SEG  = 6,
  parameter int SEG_W    = 3,
  parameter int CODE_ID  = 1,
  parameter int STACK_ID = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_req,
  input  logic [15:0]       ld_sel,
  input  logic [SEG_W-1:0]  ld_seg,
  output logic              ld_busy,
  output logic              ld_done,
  output logic [1:0]        ld_fault,
  input  logic              tbl_we,
  input  logic              tbl_local,
  input  logic [31:0]       tbl_base,
  input  logic [15:0]       tbl_limit,
  input  logic [15:0]       tbl_sel,
  output logic [15:0]       ldt_sel,
  input  logic [SEG_W-1:0]  rd_seg,
  output logic [15:0]       rd_sel,
  output logic              rd_usable,
  output logic [31:0]       rd_base,
  output logic [31:0]       rd_limit,
  output logic [11:0]       rd_attr,
  input  logic [SEG_W-1:0]  chk_seg,
  input  logic [31:0]       chk_off,
  input  logic [2:0]        chk_size,
  output logic [31:0]       chk_linear,
  output logic              chk_fault,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_wstrb,
  input  logic [31:0]       mem_rdata
);
  localparam int SEL_W  = 16;
  localparam int IDX_W  = SEL_W - 3;
  localparam int ATTR_W = 12;
  localparam int ACC_BIT = 8;
  localparam int PRS_BIT = 15;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  ld_state_e         st_q, st_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [SEG_W-1:0]  seg_q, seg_d;
  logic [31:0]       addr_q, addr_d;
  logic [31:0]       w0_q, w0_d, w1_q, w1_d;
  fault_e            flt_q, flt_d;
  logic              commit_q, commit_d;
  logic              use_q, use_d;

  logic [31:0]       desc_addr;
  logic              lim_fault;
  logic              is_null;
  logic              code_or_stack;
  logic [31:0]       u_base, u_limit;
  logic [ATTR_W-1:0] u_attr;

  seg_ld_tables #(.ADDR_W(32), .LIM_W(16), .IDX_W(IDX_W)) u_tables (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .wr_en     (tbl_we),
    .wr_local  (tbl_local),
    .wr_base   (tbl_base),
    .wr_limit  (tbl_limit),
    .wr_sel    (tbl_sel),
    .sel_hi    (ld_sel[SEL_W-1:2]),
    .desc_addr (desc_addr),
    .lim_fault (lim_fault),
    .ldt_sel   (ldt_sel)
  );

  assign is_null       = (ld_sel[SEL_W-1:2] == '0);
  assign code_or_stack = (ld_seg == SEG_W'(CODE_ID)) || (ld_seg == SEG_W'(STACK_ID));

  always_comb begin
    st_d = st_q; sel_d = sel_q; seg_d = seg_q; addr_d = addr_q;
    w0_d = w0_q; w1_d = w1_q; flt_d = flt_q; commit_d = commit_q; use_d = use_q;
    unique case (st_q)
      ST_IDLE: begin
        if (ld_req) begin
          sel_d  = ld_sel;
          seg_d  = ld_seg;
          addr_d = desc_addr;
          w0_d   = '0;
          w1_d   = '0;
          if (is_null) begin
            use_d    = 1'b0;
            flt_d    = code_or_stack ? FLT_NULLCS : FLT_NONE;
            commit_d = !code_or_stack;
            st_d     = ST_DONE;
          end else if (lim_fault) begin
            flt_d    = FLT_TABLE;
            commit_d = 1'b0;
            st_d     = ST_DONE;
          end else begin
            use_d    = 1'b1;
            flt_d    = FLT_NONE;
            commit_d = 1'b0;
            st_d     = ST_RD_LO;
          end
        end
      end
      ST_RD_LO: begin
        if (mem_ready) begin
          w0_d = mem_rdata;
          st_d = ST_RD_HI;
        end
      end
      ST_RD_HI: begin
        if (mem_ready) begin
          w1_d = mem_rdata;
          if (!mem_rdata[PRS_BIT]) begin
            flt_d = FLT_ABSENT;
            st_d  = ST_DONE;
          end else if (mem_rdata[ACC_BIT]) begin
            commit_d = 1'b1;
            st_d     = ST_DONE;
          end else begin
            w1_d[ACC_BIT] = 1'b1;
            st_d          = ST_WB;
          end
        end
      end
      ST_WB: begin
        if (mem_ready) begin
          commit_d = 1'b1;
          st_d     = ST_DONE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; sel_q <= '0; seg_q <= '0; addr_q <= '0;
      w0_q <= '0; w1_q <= '0; flt_q <= FLT_NONE; commit_q <= 1'b0; use_q <= 1'b0;
    end else begin
      st_q <= st_d; sel_q <= sel_d; seg_q <= seg_d; addr_q <= addr_d;
      w0_q <= w0_d; w1_q <= w1_d; flt_q <= flt_d; commit_q <= commit_d; use_q <= use_d;
    end
  end

  assign ld_busy   = (st_q != ST_IDLE);
  assign ld_done   = (st_q == ST_DONE);
  assign ld_fault  = flt_q;
  assign mem_valid = (st_q == ST_RD_LO) || (st_q == ST_RD_HI) || (st_q == ST_WB);
  assign mem_write = (st_q == ST_WB);
  assign mem_addr  = (st_q == ST_RD_LO) ? addr_q : addr_q + 32'd4;
  assign mem_wdata = w1_q;
  assign mem_wstrb = (st_q == ST_WB) ? 4'b0010 : 4'b0000;

  seg_ld_unpack u_unpack (
    .lo_word (w0_q),
    .hi_word (w1_q),
    .base    (u_base),
    .limit   (u_limit),
    .attr    (u_attr)
  );

  seg_ld_cache #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .SEL_W(SEL_W), .ATTR_W(ATTR_W)) u_cache (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .we       (ld_done && commit_q),
    .w_seg    (seg_q),
    .w_sel    (sel_q),
    .w_usable (use_q),
    .w_base   (u_base),
    .w_limit  (u_limit),
    .w_attr   (u_attr),
    .r_seg    (rd_seg),
    .r_sel    (rd_sel),
    .r_usable (rd_usable),
    .r_base   (rd_base),
    .r_limit  (rd_limit),
    .r_attr   (rd_attr),
    .c_seg    (chk_seg),
    .c_off    (chk_off),
    .c_size   (chk_size),
    .c_linear (chk_linear),
    .c_fault  (chk_fault)
  );

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    ld_done |=> !ld_done);

  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

  assert_null_no_mem_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ld_busy && ld_req && is_null) |=> !mem_valid);

  assert_table_no_mem_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ld_busy && ld_req && !is_null && lim_fault) |=> (!mem_valid && ld_done));

  assert_wb_byte_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (mem_valid && mem_write) |-> ((mem_wstrb == 4'b0010) && mem_wdata[ACC_BIT] && (mem_addr[1:0] == 2'b00)));
endmodule

// File: tb/seg_selector_loader_bench.sv
module seg_selector_loader_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, ld_req, ld_busy, ld_done, tbl_we, tbl_local;
  logic [15:0] ld_sel, tbl_limit, tbl_sel, ldt_sel, rd_sel;
  logic [2:0]  ld_seg, rd_seg, chk_seg, chk_size;
  logic [1:0]  ld_fault;
  logic [31:0] tbl_base, rd_base, rd_limit, chk_off, chk_linear;
  logic [11:0] rd_attr;
  logic rd_usable, chk_fault, mem_valid, mem_ready, mem_write;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_wstrb;

  seg_selector_loader u_seg_selector_loader (.*);

  logic [31:0] mem [0:1023];
  logic bd_we; logic [31:0] bd_addr, bd_data;
  int n_acc, n_wr;
  logic [31:0] rd_prev, rd_last;
  logic stall_en;
  int n_chk, n_fail;

  assign mem_rdata = mem[mem_addr[11:2]];

  always @(posedge clk) begin
    if (bd_we) mem[bd_addr[11:2]] <= bd_data;
    if (mem_valid && mem_ready) begin
      n_acc <= n_acc + 1;
      if (mem_write) begin
        n_wr <= n_wr + 1;
        for (int b = 0; b < 4; b++)
          if (mem_wstrb[b]) mem[mem_addr[11:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end else begin
        rd_prev <= rd_last;
        rd_last <= mem_addr;
      end
    end
  end

  always @(negedge clk) mem_ready = stall_en ? ~mem_ready : 1'b1;

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    bd_we = 1'b1; bd_addr = a; bd_data = d;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic do_load(input logic [2:0] seg, input logic [15:0] sel, output logic [1:0] flt);
    int t;
    ld_seg = seg; ld_sel = sel; ld_req = 1'b1;
    @(negedge clk);
    ld_req = 1'b0; t = 0;
    while (!ld_done && t < 1000) begin @(negedge clk); t++; end
    flt = ld_fault;
    if (t >= 1000) chk_eq("R11 done timeout", 32'd0, 32'd1);
    @(negedge clk);
  endtask

  task automatic write_table(input logic loc, input logic [31:0] b, input logic [15:0] l, input logic [15:0] s);
    tbl_we = 1'b1; tbl_local = loc; tbl_base = b; tbl_limit = l; tbl_sel = s;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  typedef struct packed {
    logic [2:0]  seg;
    logic [15:0] sel;
    logic [31:0] w0;
    logic [31:0] w1;
    logic [1:0]  flt;
    logic [31:0] base;
    logic [31:0] lim;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{3'd3, 16'h0008, 32'h1234_0FFF, 32'h0000_9256, 2'd0, 32'h0056_1234, 32'h0000_0FFF},
    '{3'd0, 16'h0013, 32'hABCD_0005, 32'h1280_F3EF, 2'd0, 32'h12EF_ABCD, 32'h0000_5FFF},
    '{3'd4, 16'h000C, 32'h0000_FFFF, 32'h008F_9A00, 2'd0, 32'h0000_0000, 32'hFFFF_FFFF},
    '{3'd5, 16'h00F8, 32'h4000_0010, 32'h000F_9201, 2'd0, 32'h0001_4000, 32'h000F_0010},
    '{3'd3, 16'h0100, 32'h0000_0000, 32'h0000_0000, 2'd1, 32'h0, 32'h0},
    '{3'd1, 16'h0010, 32'h0000_0000, 32'h0000_1A00, 2'd2, 32'h0, 32'h0},
    '{3'd2, 16'h0001, 32'h0000_0000, 32'h0000_0000, 2'd3, 32'h0, 32'h0},
    '{3'd1, 16'h0004, 32'h0000_00FF, 32'h0040_9B00, 2'd0, 32'h0000_0000, 32'h0000_00FF}
  };

  vec_t v;
  logic [31:0] ea, b_base;
  logic b_use;
  logic [1:0] f;
  int acc0, wr0;

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; n_acc = 0; n_wr = 0; rd_prev = '0; rd_last = '0;
    rst_n = 1'b0; ld_req = 1'b0; ld_sel = '0; ld_seg = '0; tbl_we = 1'b0; tbl_local = 1'b0;
    tbl_base = '0; tbl_limit = '0; tbl_sel = '0; rd_seg = '0; chk_seg = 3'd3; chk_off = '0;
    chk_size = 3'd1; stall_en = 1'b0; mem_ready = 1'b1; bd_we = 1'b0; bd_addr = '0; bd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    chk_eq("R9 ldt_sel", 32'(ldt_sel), 32'h0);
    rd_seg = 3'd0; chk_eq("R9 usable", 32'(rd_usable), 32'h0);
    chk_eq("R9 sel", 32'(rd_sel), 32'h0);
    rd_seg = 3'd5; chk_eq("R9 usable gs", 32'(rd_usable), 32'h0);
    chk_eq("R9 chk fault", 32'(chk_fault), 32'h1);
    poke(32'h0000_FFF8, 32'h0); poke(32'h0000_FFFC, 32'h0);
    do_load(3'd3, 16'hFFF8, f);
    chk_eq("R9 global limit ffff", 32'(f), 32'd2);
    chk_eq("R9 global base 0", rd_prev, 32'h0000_FFF8);
    do_load(3'd3, 16'hFFFC, f);
    chk_eq("R9 local limit ffff", 32'(f), 32'd2);
    chk_eq("R9 local base 0", rd_prev, 32'h0000_FFF8);

    // R12 table writes
    write_table(1'b0, 32'h100, 16'h00FF, 16'h0);
    write_table(1'b1, 32'h800, 16'h003F, 16'h0028);
    chk_eq("R12 ldt_sel", 32'(ldt_sel), 32'h0028);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      stall_en = i[0];
      ea = (v.sel[2] ? 32'h800 : 32'h100) + {16'h0, v.sel[15:3], 3'b000};
      poke(ea, v.w0); poke(ea + 32'd4, v.w1);
      rd_seg = v.seg;
      @(negedge clk);
      b_base = rd_base; b_use = rd_usable;
      acc0 = n_acc; wr0 = n_wr;
      do_load(v.seg, v.sel, f);
      stall_en = 1'b0;
      @(negedge clk);
      case (v.flt)
        2'd0: chk_eq("R11 fault none", 32'(f), 32'd0);
        2'd1: chk_eq("R4 fault table", 32'(f), 32'd1);
        2'd2: chk_eq("R5 fault absent", 32'(f), 32'd2);
        default: chk_eq("R3 fault null", 32'(f), 32'd3);
      endcase
      if (v.flt == 2'd0) begin
        chk_eq(v.sel[2] ? "R1 local addr" : "R2 global addr", rd_prev, ea);
        chk_eq("R2 second word", rd_last, ea + 32'd4);
        chk_eq("R1 sel", 32'(rd_sel), 32'(v.sel));
        chk_eq("R6 base", rd_base, v.base);
        chk_eq(v.w1[23] ? "R7 limit gran" : "R6 limit", rd_limit, v.lim);
        chk_eq("R6 attr", 32'(rd_attr), {20'h0, v.w1[23:20], v.w1[15:9], 1'b1});
        chk_eq("R8 write count", 32'(n_wr - wr0), v.w1[8] ? 32'd0 : 32'd1);
        chk_eq("R8 memory word", mem[ea[11:2] + 10'd1], v.w1 | 32'h100);
      end else begin
        chk_eq("R5 base kept", rd_base, b_base);
        chk_eq("R5 usable kept", 32'(rd_usable), 32'(b_use));
        chk_eq("R8 no write on fault", 32'(n_wr - wr0), 32'd0);
        if (v.flt != 2'd2) chk_eq("R4 no memory", 32'(n_acc - acc0), 32'd0);
      end
    end

    // R3 null selector into a data register
    acc0 = n_acc;
    do_load(3'd3, 16'h0003, f);
    rd_seg = 3'd3; chk_seg = 3'd3; chk_off = 32'h0; chk_size = 3'd1;
    @(negedge clk);
    chk_eq("R3 null fault", 32'(f), 32'd0);
    chk_eq("R3 null no memory", 32'(n_acc - acc0), 32'd0);
    chk_eq("R3 null unusable", 32'(rd_usable), 32'd0);
    chk_eq("R3 null sel", 32'(rd_sel), 32'h0003);
    chk_eq("R10 null access faults", 32'(chk_fault), 32'd1);

    // R10 access checks on the last byte
    chk_seg = 3'd0; chk_off = 32'h5FFC; chk_size = 3'd4; @(negedge clk);
    chk_eq("R10 in range", 32'(chk_fault), 32'd0);
    chk_eq("R10 linear", chk_linear, 32'h12F0_0BC9);
    chk_off = 32'h5FFD; @(negedge clk);
    chk_eq("R10 past limit", 32'(chk_fault), 32'd1);
    chk_seg = 3'd4; chk_off = 32'hFFFF_FFFC; @(negedge clk);
    chk_eq("R10 top of 4G", 32'(chk_fault), 32'd0);
    chk_off = 32'hFFFF_FFFD; @(negedge clk);
    chk_eq("R10 wrap faults", 32'(chk_fault), 32'd1);
    chk_seg = 3'd5; chk_off = 32'h000F_0010; chk_size = 3'd1; @(negedge clk);
    chk_eq("R10 byte limit edge", 32'(chk_fault), 32'd0);

    // R11 request while busy is ignored
    ld_seg = 3'd2; ld_sel = 16'h0008; ld_req = 1'b1;
    @(negedge clk);
    chk_eq("R11 busy", 32'(ld_busy), 32'd1);
    ld_seg = 3'd2; ld_sel = 16'h0008;
    @(negedge clk);
    ld_req = 1'b0;
    while (!ld_done) @(negedge clk);
    ld_seg = 3'd0; ld_sel = 16'h0008; ld_req = 1'b1;
    @(negedge clk);
    ld_req = 1'b0;
    while (ld_busy) @(negedge clk);
    rd_seg = 3'd0; @(negedge clk);
    chk_eq("R11 request during busy ignored", rd_base, 32'h12EF_ABCD);
    rd_seg = 3'd2; @(negedge clk);
    chk_eq("R11 first request loaded", rd_base, 32'h0056_1234);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule